// File: doc/BRIEF.md
# Table-Shaped Gaussian Noise Source

This block turns a stream of uniformly distributed random words, typically produced by a pseudorandom generator, into normally distributed samples with a programmable centre and spread. Each uniform word is split in two. The top bit is a sign. The lower bits index a table that holds one half of the inverse cumulative normal curve, so the table returns a non-negative unit-variance magnitude.

That magnitude is multiplied by a standard deviation and rounded back to integer scale. It is then added to or subtracted from a mean, depending on the sign bit. The result is clamped to the signed output range rather than allowed to wrap.

Software loads the table through a synchronous write port, so no initial file is needed. The result emerges from a fixed three-stage pipeline: table fetch, scaling, then offset with clamping. Because the curve is symmetric, a table of a given size gives twice the resolution that a full-range table of the same size would give.

Top module: `gauss_noise_gen`

## Requirements
- R1: After reset is released and before any sample is issued, `noise_vld` is 0 and `noise_out` is 0.
- R2: `noise_vld` is high in exactly the cycle that comes three clock cycles after a cycle in which `uni_vld` was high, and is low otherwise.
- R3: When bit 8 of `uni_word` is 0, the result is mean + M. M = floor((T[a] * S + 32768) / 65536), where T[a] is the unsigned Q4.8 table entry at address a and S is the unsigned Q4.8 value of `sigma_q`.
- R4: When bit 8 of `uni_word` is 1, the result is mean - M, with M defined as in R3.
- R5: Bits 7:0 of `uni_word` are the table address a. Addresses 0 and 255 both reach their own entries.
- R6: A table entry written with `tbl_we` high at address `tbl_waddr` is the value used by every later sample that reads that address.
- R7: With `sigma_q` equal to 0, the result equals the mean whatever the sign and address.
- R8: A result above 32767 is output as 32767, never as a wrapped value.
- R9: A result below -32768 is output as -32768, never as a wrapped value.
- R10: `mean_val` and `sigma_q` are captured in the same cycle as the uniform word. A change to either in the following cycle does not alter that sample's result.
- R11: `noise_out` keeps its last value through cycles in which no result is due.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 8 | Table write address |
| tbl_wdata | input | 12 | Table entry, unsigned Q4.8 |
| sigma_q | input | 12 | Standard deviation, unsigned Q4.8 |
| mean_val | input | 16 | Mean, signed integer |
| uni_vld | input | 1 | Uniform word valid |
| uni_word | input | 9 | Uniform word: bit 8 sign, bits 7:0 table address |
| noise_vld | output | 1 | Result valid |
| noise_out | output | 16 | Gaussian sample, signed, saturated |

## Verification
Each result becomes visible three rising edges after the edge that samples its uniform word. The bench drives inputs on falling edges and reads `noise_out` on the third falling edge after issue. When checking latency, it also confirms that `noise_vld` is low on the second and fourth falling edges. For back-to-back samples, each result is read on consecutive falling edges starting three after the first issue. To test capture timing, the mean and sigma are changed one falling edge after issue, and the result is still compared with the value computed from the original settings.

// File: rtl/gng_pkg.sv
package gng_pkg;
    localparam int ADDR_W  = 8;
    localparam int TBL_W   = 12;
    localparam int SIG_W   = 12;
    localparam int FRAC_W  = 8;
    localparam int DATA_W  = 16;
    localparam int UNI_W   = ADDR_W + 1;
    localparam int PROD_W  = TBL_W + SIG_W;
    localparam int MAG_W   = PROD_W - 2 * FRAC_W + 1;
    localparam int SUM_W   = DATA_W + 2;
endpackage

// File: rtl/gng_half_table.sv
module gng_half_table #(
    parameter int ADDR_W = 8,
    parameter int TBL_W  = 12,
    parameter int SIG_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        waddr_i,
    input  logic [TBL_W-1:0]         wdata_i,
    input  logic                     rd_en_i,
    input  logic [ADDR_W-1:0]        raddr_i,
    input  logic                     neg_i,
    input  logic [SIG_W-1:0]         sigma_i,
    input  logic signed [DATA_W-1:0] mean_i,
    output logic                     vld_o,
    output logic                     neg_o,
    output logic [TBL_W-1:0]         tval_o,
    output logic [SIG_W-1:0]         sigma_o,
    output logic signed [DATA_W-1:0] mean_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [TBL_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            store_q[waddr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            neg_o   <= 1'b0;
            tval_o  <= '0;
            sigma_o <= '0;
            mean_o  <= '0;
        end else begin
            vld_o <= rd_en_i;
            if (rd_en_i) begin
                neg_o   <= neg_i;
                tval_o  <= store_q[raddr_i];
                sigma_o <= sigma_i;
                mean_o  <= mean_i;
            end
        end
    end

    // R2
    fetch_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> vld_o);

    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> ($stable(mean_o) && $stable(sigma_o)));
endmodule

// File: rtl/gng_scaler.sv
module gng_scaler #(
    parameter int TBL_W  = 12,
    parameter int SIG_W  = 12,
    parameter int FRAC_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic                     neg_i,
    input  logic [TBL_W-1:0]         tval_i,
    input  logic [SIG_W-1:0]         sigma_i,
    input  logic signed [DATA_W-1:0] mean_i,
    output logic                     vld_o,
    output logic                     neg_o,
    output logic [TBL_W+SIG_W-2*FRAC_W:0] mag_o,
    output logic signed [DATA_W-1:0] mean_o
);
    localparam int PROD_W = TBL_W + SIG_W;
    localparam int SHIFT  = 2 * FRAC_W;
    localparam int MAG_W  = PROD_W - SHIFT + 1;
    localparam logic [PROD_W:0] HALF = (PROD_W + 1)'(1) << (SHIFT - 1);

    logic [PROD_W:0] prod_w;
    logic [PROD_W:0] rnd_w;
    logic [MAG_W-1:0] mag_w;

    always_comb begin
        prod_w = {1'b0, ({{SIG_W{1'b0}}, tval_i} * {{TBL_W{1'b0}}, sigma_i})};
        rnd_w  = (prod_w + HALF) >> SHIFT;
        mag_w  = rnd_w[MAG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            neg_o  <= 1'b0;
            mag_o  <= '0;
            mean_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                neg_o  <= neg_i;
                mag_o  <= mag_w;
                mean_o <= mean_i;
            end
        end
    end

    // R2
    scale_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);

    // R7
    zero_sigma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && sigma_i == '0) |=> mag_o == '0);
endmodule

// File: rtl/gng_combiner.sv
module gng_combiner #(
    parameter int MAG_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic                     neg_i,
    input  logic [MAG_W-1:0]         mag_i,
    input  logic signed [DATA_W-1:0] mean_i,
    output logic                     vld_o,
    output logic signed [DATA_W-1:0] val_o
);
    localparam int SUM_W = DATA_W + 2;
    localparam logic signed [SUM_W-1:0] MAX_S =
        {{(SUM_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] MIN_S =
        {{(SUM_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [SUM_W-1:0] mean_x;
    logic signed [SUM_W-1:0] mag_x;
    logic signed [SUM_W-1:0] sum_w;
    logic signed [DATA_W-1:0] clip_w;

    always_comb begin
        mean_x = {{(SUM_W-DATA_W){mean_i[DATA_W-1]}}, mean_i};
        mag_x  = {{(SUM_W-MAG_W){1'b0}}, mag_i};
        sum_w  = neg_i ? (mean_x - mag_x) : (mean_x + mag_x);
        if (sum_w > MAX_S) begin
            clip_w = MAX_S[DATA_W-1:0];
        end else if (sum_w < MIN_S) begin
            clip_w = MIN_S[DATA_W-1:0];
        end else begin
            clip_w = sum_w[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            val_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                val_o <= clip_w;
            end
        end
    end

    // R8
    no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !neg_i) |=> val_o >= $past(mean_i));

    // R9
    no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && neg_i) |=> val_o <= $past(mean_i));

    // R11
    hold_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(val_o));

    // R7
    mean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && mag_i == '0) |=> val_o == $past(mean_i));
endmodule

// File: rtl/gauss_noise_gen.sv
module gauss_noise_gen
    import gng_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tbl_we,
    input  logic [ADDR_W-1:0]        tbl_waddr,
    input  logic [TBL_W-1:0]         tbl_wdata,
    input  logic [SIG_W-1:0]         sigma_q,
    input  logic signed [DATA_W-1:0] mean_val,
    input  logic                     uni_vld,
    input  logic [UNI_W-1:0]         uni_word,
    output logic                     noise_vld,
    output logic signed [DATA_W-1:0] noise_out
);
    logic                     f_vld, f_neg;
    logic [TBL_W-1:0]         f_tval;
    logic [SIG_W-1:0]         f_sigma;
    logic signed [DATA_W-1:0] f_mean;

    logic                     s_vld, s_neg;
    logic [MAG_W-1:0]         s_mag;
    logic signed [DATA_W-1:0] s_mean;

    gng_half_table #(
        .ADDR_W(ADDR_W), .TBL_W(TBL_W), .SIG_W(SIG_W), .DATA_W(DATA_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .we_i(tbl_we), .waddr_i(tbl_waddr), .wdata_i(tbl_wdata),
        .rd_en_i(uni_vld), .raddr_i(uni_word[ADDR_W-1:0]),
        .neg_i(uni_word[UNI_W-1]), .sigma_i(sigma_q), .mean_i(mean_val),
        .vld_o(f_vld), .neg_o(f_neg), .tval_o(f_tval),
        .sigma_o(f_sigma), .mean_o(f_mean)
    );

    gng_scaler #(
        .TBL_W(TBL_W), .SIG_W(SIG_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)
    ) u_scale (
        .clk(clk), .rst_n(rst_n),
        .vld_i(f_vld), .neg_i(f_neg), .tval_i(f_tval),
        .sigma_i(f_sigma), .mean_i(f_mean),
        .vld_o(s_vld), .neg_o(s_neg), .mag_o(s_mag), .mean_o(s_mean)
    );

    gng_combiner #(
        .MAG_W(MAG_W), .DATA_W(DATA_W)
    ) u_comb (
        .clk(clk), .rst_n(rst_n),
        .vld_i(s_vld), .neg_i(s_neg), .mag_i(s_mag), .mean_i(s_mean),
        .vld_o(noise_vld), .val_o(noise_out)
    );

    // R2
    out_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_vld |=> noise_vld);
endmodule

// File: tb/gauss_noise_gen_tb.sv
module gauss_noise_gen_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_we = 1'b0;
    logic [7:0] tbl_waddr = '0;
    logic [11:0] tbl_wdata = '0;
    logic [11:0] sigma_q = '0;
    logic signed [15:0] mean_val = '0;
    logic uni_vld = 1'b0;
    logic [8:0] uni_word = '0;
    logic noise_vld;
    logic signed [15:0] noise_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5ns clk = ~clk;

    gauss_noise_gen u_dut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .sigma_q(sigma_q), .mean_val(mean_val),
        .uni_vld(uni_vld), .uni_word(uni_word),
        .noise_vld(noise_vld), .noise_out(noise_out)
    );

    typedef struct packed {
        logic               neg;
        logic [7:0]         adr;
        logic [11:0]        sig;
        logic signed [15:0] mu;
        logic signed [15:0] want;
    } vec_t;

    // table entry at address a is a*16+15
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd0,   12'd256,  16'sd100,    16'sd100},    // R3 R5 addr 0
        '{1'b0, 8'd255, 12'd256,  16'sd100,    16'sd116},    // R3 R5 addr 255
        '{1'b1, 8'd255, 12'd256,  16'sd100,    16'sd84},     // R4
        '{1'b1, 8'd0,   12'd4095, -16'sd50,    -16'sd51},    // R4 R5
        '{1'b0, 8'd128, 12'd4095, 16'sd0,      16'sd129},    // R3
        '{1'b1, 8'd255, 12'd4095, -16'sd32700, -16'sd32768}, // R9
        '{1'b0, 8'd255, 12'd4095, 16'sd32700,  16'sd32767},  // R8
        '{1'b1, 8'd77,  12'd0,    16'sd1234,   16'sd1234},   // R7
        '{1'b0, 8'd64,  12'd512,  -16'sd10,    -16'sd2}      // R3
    };

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic neg, input logic [7:0] adr,
                         input logic [11:0] sig, input logic signed [15:0] mu);
        uni_vld  = 1'b1;
        uni_word = {neg, adr};
        sigma_q  = sig;
        mean_val = mu;
        @(negedge clk);
        uni_vld  = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 vld", longint'(noise_vld), 0);
        check("R1 val", longint'(noise_out), 0);

        // R6 load table
        for (int a = 0; a < 256; a++) begin
            tbl_we = 1'b1;
            tbl_waddr = 8'(a);
            tbl_wdata = 12'(a * 16 + 15);
            @(negedge clk);
        end
        tbl_we = 1'b0;
        @(negedge clk);

        // vector walk: result due on third falling edge after issue
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].neg, VECS[i].adr, VECS[i].sig, VECS[i].mu);
            repeat (2) @(negedge clk);
            check($sformatf("R3/R4/R5/R7/R8/R9 vec%0d", i),
                  longint'(noise_out), longint'(VECS[i].want));
        end

        // R2 latency
        issue(1'b0, 8'd10, 12'd256, 16'sd0);
        check("R2 edge1", longint'(noise_vld), 0);
        @(negedge clk);
        check("R2 edge2", longint'(noise_vld), 0);
        @(negedge clk);
        check("R2 edge3", longint'(noise_vld), 1);
        @(negedge clk);
        check("R2 edge4", longint'(noise_vld), 0);

        // R11 hold: last result was 0 + round(175*256/65536)=1
        repeat (3) @(negedge clk);
        check("R11 hold", longint'(noise_out), 1);

        // R10 capture: change mean and sigma next cycle
        uni_vld = 1'b1; uni_word = {1'b0, 8'd255}; sigma_q = 12'd256; mean_val = 16'sd500;
        @(negedge clk);
        uni_vld = 1'b0; sigma_q = 12'd4095; mean_val = -16'sd900;
        repeat (2) @(negedge clk);
        check("R10 capture", longint'(noise_out), 516);

        // R6 rewrite entry 3 then read it
        tbl_we = 1'b1; tbl_waddr = 8'd3; tbl_wdata = 12'd2048;
        @(negedge clk);
        tbl_we = 1'b0;
        issue(1'b0, 8'd3, 12'd256, 16'sd0);
        repeat (2) @(negedge clk);
        check("R6 rewrite", longint'(noise_out), 8);

        // R2 back to back
        uni_vld = 1'b1; sigma_q = 12'd256; mean_val = 16'sd0;
        uni_word = {1'b0, 8'd255}; @(negedge clk);
        uni_word = {1'b1, 8'd255}; @(negedge clk);
        uni_word = {1'b0, 8'd3};   @(negedge clk);
        uni_vld = 1'b0;
        check("R2 b2b0", longint'(noise_out), 16);
        @(negedge clk);
        check("R2 b2b1", longint'(noise_out), -16);
        @(negedge clk);
        check("R2 b2b2", longint'(noise_out), 8);
        check("R2 b2b vld", longint'(noise_vld), 1);
        @(negedge clk);
        check("R2 b2b end", longint'(noise_vld), 0);

        finish_run();
    end
endmodule